// File: doc/BRIEF.md
# In-Band Carrier Detect Qualifier

This block decides whether a carrier is present in the data band of a line receiver. A band-pass level comparator, outside this block, raises an "energy present" flag on any clock cycle in which the filtered signal exceeds its threshold. The block turns that raw flag into a clean, active-low carrier-detect output. The output falls only after the activity has persisted long enough to rule out clicks and short bursts. It then rides through short dropouts and rises again only after a fixed stretch of silence.

Time is measured in millisecond windows. An internal divider derives these windows from the system clock. The block records one bit per window, which is set if any synchronised sample in that window showed energy. Qualification requires that a minimum number of the most recent windows were active. The hold timer counts silent windows and is restarted by every active sample. A power-down input returns the output to its inactive state and discards all history, so qualification starts from scratch after power-up. The output is meant to gate downstream bit recovery and to feed an interrupt combiner.

Top module: `cdq_carrier_qual`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `cd_n` is 1. Reset clears the window history, the hold timer and the window divider.
- R2: `cd_n` goes low (carrier present) only when at least NEED of the last WINDOWS completed windows held activity. The active windows need not be consecutive.
- R3: With activity in every window, `cd_n` falls after the NEED-th window completes. That is at most NEED+1 ms after onset, which is 7 ms with the defaults and so well inside 25 ms.
- R4: With only NEED-1 active windows among the last WINDOWS, `cd_n` stays high.
- R5: Once `cd_n` is low, a run of up to HOLD_MS-1 silent windows followed by an active one does not release it.
- R6: `cd_n` returns high at the end of the HOLD_MS-th consecutive silent window. At that moment the window history is emptied, so a fresh qualification is needed before `cd_n` can fall again.
- R7: `pwdn` high forces `cd_n` to 1 on the next clock edge and keeps it there. It also clears the history, the hold timer and the window divider. After `pwdn` falls, qualification restarts with no memory of earlier activity.
- R8: `energy_in` passes through a two-flop synchroniser. A single-cycle pulse anywhere inside a window marks that window as active.
- R9: The hold timer restarts on every synchronised active sample. Silence is therefore counted from the last activity, never accumulated across bursts, and the timer never reaches HOLD_MS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwdn | input | 1 | Power-down; forces the output inactive and clears all history |
| energy_in | input | 1 | Raw per-sample band energy flag from the level comparator (asynchronous) |
| cd_n | output | 1 | Registered carrier detect, active low |

## Verification
Corruption in the window history shows up at the port as a fall of `cd_n` that comes one or more windows too early or too late. It can also show up as a fall after a sparse pattern that should have been rejected. All of these are visible within the millisecond in which the wrong window completes. A hold timer that skips or misses a restart moves the rise of `cd_n` by whole windows. The same is true of a history that is not emptied on release, which lets the output fall again immediately after a release. For this reason the stimulus is aligned to window boundaries and the output is sampled a few cycles into each following window. Every discrepancy then lands on a precise window.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

    typedef enum logic [0:0] {
        CDQ_IDLE = 1'b0,
        CDQ_LOCK = 1'b1
    } cdq_state_e;

    // One synchronised sample together with the window boundary strobe
    typedef struct packed {
        logic tick;
        logic act;
    } cdq_sample_t;

    // Bits needed to hold a count from 0 to n inclusive
    function automatic int cnt_width(input int n);
        if (n < 1) return 1;
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cdq_sync.sv
module cdq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) ff[0] <= 1'b0;
                else     ff[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) ff[g] <= 1'b0;
                else     ff[g] <= ff[g-1];
            end
        end
    end

    assign dout = ff[STAGES-1];
endmodule

// File: rtl/cdq_ms_tick.sv
module cdq_ms_tick #(
    parameter int CLKS_PER_MS = 250000
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int W = (CLKS_PER_MS < 2) ? 1 : $clog2(CLKS_PER_MS);
    localparam logic [W-1:0] LAST = W'(CLKS_PER_MS - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (clr)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cdq_window.sv
module cdq_window
    import cdq_pkg::*;
#(
    parameter int WINDOWS = 8,
    parameter int NEED    = 6,
    localparam int CW     = cnt_width(WINDOWS)
) (
    input  logic        clk,
    input  logic        clr,
    input  cdq_sample_t smp,
    output logic        qual,
    output logic [CW-1:0] score
);
    logic               seen;
    logic [WINDOWS-1:0] hist;

    always_ff @(posedge clk) begin
        if (clr) begin
            seen <= 1'b0;
            hist <= '0;
        end else if (smp.tick) begin
            hist <= {hist[WINDOWS-2:0], seen | smp.act};
            seen <= 1'b0;
        end else if (smp.act) begin
            seen <= 1'b1;
        end
    end

    assign score = CW'($countones(hist));
    assign qual  = (score >= CW'(NEED));
endmodule

// File: rtl/cdq_hold.sv
module cdq_hold
    import cdq_pkg::*;
#(
    parameter int HOLD_MS = 8,
    localparam int HW     = cnt_width(HOLD_MS)
) (
    input  logic          clk,
    input  logic          clr,
    input  cdq_sample_t   smp,
    output logic          expire,
    output logic [HW-1:0] count
);
    localparam logic [HW-1:0] LASTH = HW'(HOLD_MS - 1);

    logic at_last;

    assign at_last = (count == LASTH);
    assign expire  = smp.tick & ~smp.act & at_last;

    always_ff @(posedge clk) begin
        if (clr)           count <= '0;
        else if (smp.act)  count <= '0;
        else if (smp.tick) count <= at_last ? '0 : count + 1'b1;
    end
endmodule

// File: rtl/cdq_carrier_qual.sv
module cdq_carrier_qual
    import cdq_pkg::*;
#(
    parameter int CLKS_PER_MS = 250000,
    parameter int WINDOWS     = 8,
    parameter int NEED        = 6,
    parameter int HOLD_MS     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwdn,
    input  logic energy_in,
    output logic cd_n
);
    localparam int CW = cnt_width(WINDOWS);
    localparam int HW = cnt_width(HOLD_MS);

    logic          halt;
    logic          act_s;
    logic          tick;
    logic          qual;
    logic          expire;
    logic          release_now;
    logic [CW-1:0] score;
    logic [HW-1:0] hold_cnt;
    cdq_sample_t   smp;
    cdq_state_e    state;

    assign halt        = rst | pwdn;
    assign smp.act     = act_s;
    assign smp.tick    = tick;
    assign release_now = (state == CDQ_LOCK) & expire;

    cdq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (energy_in),
        .dout (act_s)
    );

    cdq_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk  (clk),
        .clr  (halt),
        .tick (tick)
    );

    cdq_window #(.WINDOWS(WINDOWS), .NEED(NEED)) u_window (
        .clk   (clk),
        .clr   (halt | release_now),
        .smp   (smp),
        .qual  (qual),
        .score (score)
    );

    cdq_hold #(.HOLD_MS(HOLD_MS)) u_hold (
        .clk    (clk),
        .clr    (halt | (state != CDQ_LOCK)),
        .smp    (smp),
        .expire (expire),
        .count  (hold_cnt)
    );

    always_ff @(posedge clk) begin
        if (halt) begin
            state <= CDQ_IDLE;
            cd_n  <= 1'b1;
        end else if (state == CDQ_IDLE) begin
            if (qual) begin
                state <= CDQ_LOCK;
                cd_n  <= 1'b0;
            end
        end else if (release_now) begin
            state <= CDQ_IDLE;
            cd_n  <= 1'b1;
        end
    end
endmodule

// File: rtl/cdq_carrier_qual_chk.sv
module cdq_carrier_qual_chk
    import cdq_pkg::*;
#(
    parameter int WINDOWS = 8,
    parameter int HOLD_MS = 8,
    localparam int CW     = cnt_width(WINDOWS),
    localparam int HW     = cnt_width(HOLD_MS)
) (
    input logic          clk,
    input logic          rst,
    input logic          pwdn,
    input logic          cd_n,
    input logic          tick,
    input logic          act_s,
    input logic          qual,
    input logic [CW-1:0] score,
    input logic [HW-1:0] hold_cnt
);
    // R2: a fall of the output is always preceded by a qualified history
    p_fall_needs_qual_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(cd_n) && !$past(rst)) |-> ($past(qual) && !$past(pwdn)));

    // R7: power-down drives the output inactive on the next edge
    p_pwdn_forces_high_r7: assert property (@(posedge clk) disable iff (rst)
        pwdn |=> cd_n);

    // R6: a release not caused by power-down happens only at a silent window end
    p_release_after_silence_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(cd_n) && !$past(pwdn) && !$past(rst)) |-> ($past(tick) && !$past(act_s)));

    // R6: the history is empty straight after any release
    p_clear_on_release_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(cd_n) && !$past(rst)) |-> (score == '0));

    // R5: an active sample while locked never lets the output go
    p_activity_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (!cd_n && act_s && !pwdn) |=> !cd_n);

    // R9: the hold timer stays below the hold length
    p_hold_bound_r9: assert property (@(posedge clk) disable iff (rst)
        hold_cnt < HW'(HOLD_MS));
endmodule

bind cdq_carrier_qual cdq_carrier_qual_chk #(
    .WINDOWS (WINDOWS),
    .HOLD_MS (HOLD_MS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwdn     (pwdn),
    .cd_n     (cd_n),
    .tick     (tick),
    .act_s    (act_s),
    .qual     (qual),
    .score    (score),
    .hold_cnt (hold_cnt)
);

// File: tb/cdq_carrier_qual_test.sv
module cdq_carrier_qual_test;

    localparam int CPM  = 16;
    localparam int NVEC = 63;

    // Each entry: {energy during the window, expected cd_n after the window}
    localparam logic [1:0] VEC [NVEC] = '{
        // R3: continuous activity, falls after the 6th window
        2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b10,
        // R5: seven silent windows then activity, stays low
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10,
        // R6: eighth silent window releases
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01,
        // R2: six of eight with gaps qualifies
        2'b11, 2'b01, 2'b11, 2'b11, 2'b01, 2'b11, 2'b11, 2'b10,
        // R6: release again
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01,
        // R4: five of eight stays high, sliding to six falls
        2'b11, 2'b11, 2'b01, 2'b11, 2'b11, 2'b01, 2'b11, 2'b01, 2'b11, 2'b11, 2'b10,
        // R9: silence, one active window, silence: counted from the last activity
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10,
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwdn = 1'b0;
    logic energy_in = 1'b0;
    logic cd_n;

    int checks = 0;
    int errors = 0;
    logic prev_exp;

    always #2 clk = ~clk;

    cdq_carrier_qual #(
        .CLKS_PER_MS (CPM),
        .WINDOWS     (8),
        .NEED        (6),
        .HOLD_MS     (8)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .pwdn      (pwdn),
        .energy_in (energy_in),
        .cd_n      (cd_n)
    );

    task automatic check(input logic got, input logic expv, input string tag);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: cd_n=%0b expected %0b at %0t", tag, got, expv, $time);
        end
    endtask

    function automatic string tag_for(input int k);
        if (k < 0)  return "R1";
        if (k < 6)  return "R3";
        if (k < 14) return "R5";
        if (k < 22) return "R6";
        if (k < 30) return "R2";
        if (k < 38) return "R6";
        if (k < 49) return "R4";
        return "R9";
    endfunction

    // Called at the negedge two cycles before a window starts in the design.
    // Checks the result of the previous window a few cycles into this one.
    task automatic run_slot(input logic a, input logic pulse, input logic expv, input string tag);
        energy_in = pulse ? 1'b0 : a;
        repeat (4) @(posedge clk);
        #1;
        check(cd_n, expv, tag);
        if (pulse) begin
            energy_in = 1'b1;
            @(posedge clk);
            #1;
            energy_in = 1'b0;
            repeat (CPM - 5) @(posedge clk);
        end else begin
            repeat (CPM - 4) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic align_after_release();
        repeat (CPM - 2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: output inactive during reset
        repeat (5) @(posedge clk);
        #1;
        check(cd_n, 1'b1, "R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(cd_n, 1'b1, "R1 after reset");
        @(negedge clk);
        repeat (CPM - 3) @(posedge clk);
        @(negedge clk);

        // Table walk
        prev_exp = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            run_slot(VEC[i][1], 1'b0, prev_exp, tag_for(i - 1));
            prev_exp = VEC[i][0];
        end
        run_slot(1'b1, 1'b0, prev_exp, tag_for(NVEC - 1));

        // Lock again: the slot above was the first active one
        for (int i = 0; i < 5; i++) run_slot(1'b1, 1'b0, 1'b1, "R3 relock");
        run_slot(1'b1, 1'b0, 1'b0, "R3 relock");

        // R7: power-down while locked
        pwdn = 1'b1;
        @(posedge clk);
        #1;
        check(cd_n, 1'b1, "R7 pwdn next edge");
        repeat (3 * CPM) @(posedge clk);
        #1;
        check(cd_n, 1'b1, "R7 pwdn with energy");
        energy_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        pwdn = 1'b0;
        align_after_release();

        // R7/R8: qualification restarts; single-cycle pulses mark windows
        run_slot(1'b1, 1'b1, 1'b1, "R7 restart");
        for (int i = 0; i < 5; i++) run_slot(1'b1, 1'b1, 1'b1, "R8 pulse windows");
        run_slot(1'b0, 1'b0, 1'b0, "R8 six pulse windows");
        run_slot(1'b0, 1'b0, 1'b0, "R5 hold after pulses");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule